// File: doc/BRIEF.md
# Scanning Beamformer with Peak Power Search

This block forms a receive beam from eight antenna channels. Every clock it can take one snapshot: a complex baseband sample (I and Q) per channel, a complex steering weight per channel, and the address of that weight in the scan table. It multiplies each channel's sample by its weight, sums the eight products, squares the magnitude of the sum and reports that power together with the weight address that produced it.

The weight changes from one snapshot to the next. A single pass over the scan table therefore yields the whole spatial power spectrum, one point per table entry. While a scan runs, the block keeps the largest power seen and the address where it first occurred. When the last entry of the scan has left the pipeline, it pulses a done flag with the final peak, so the caller can turn the peak address into an arrival angle. The table contents and the address-to-angle mapping live outside this block.

Top module: `scan_beamformer`

## Requirements
- R1: For each channel the weighted product is re = (I*Wr - Q*Wi) and im = (I*Wi + Q*Wr), computed at full precision and then arithmetically shifted right by 15 (weights are signed Q1.15), so negative results round toward minus infinity (for example I = -3, Wr = 1 gives -1).
- R2: The reported power is re_sum^2 + im_sum^2 of the sums of the eight channel products, presented as a 49-bit value whose top bit is always 0.
- R3: A sample accepted with smp_valid high at clock edge k produces pw_valid high after edge k+2, for exactly one cycle per accepted sample.
- R4: pw_addr carries the wt_addr that was presented with the sample that produced pw_power.
- R5: A cycle with smp_valid low produces no power output (pw_valid low two edges later).
- R6: The sample tagged with scan_start loads the peak registers unconditionally, discarding the peak of any earlier scan.
- R7: Within a scan the peak is replaced only by a strictly larger power; on equal powers the earlier address is kept.
- R8: One cycle after the power of the sample tagged scan_last is output, scan_done is high for one cycle and peak_power and peak_addr hold the peak of that scan.
- R9: After reset pw_valid, scan_done, pw_power, pw_addr, peak_power and peak_addr are all zero.
- R10: scan_start and scan_last have no effect in cycles where smp_valid is low: no done pulse and no clearing of the peak.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | A snapshot is presented this cycle |
| scan_start | input | 1 | This snapshot is the first of a scan |
| scan_last | input | 1 | This snapshot is the last of a scan |
| wt_addr | input | 11 | Scan table address of the weights |
| smp_i | input | 160 | Per-channel I samples, channel n at bits [20n+19:20n], signed |
| smp_q | input | 160 | Per-channel Q samples, same packing |
| wt_re | input | 128 | Per-channel weight real parts, channel n at bits [16n+15:16n], signed Q1.15 |
| wt_im | input | 128 | Per-channel weight imaginary parts, same packing |
| pw_valid | output | 1 | pw_power and pw_addr are valid |
| pw_power | output | 49 | Beam power for one weight |
| pw_addr | output | 11 | Weight address paired with pw_power |
| scan_done | output | 1 | One-cycle pulse after the last entry of a scan |
| peak_power | output | 49 | Largest power of the current scan |
| peak_addr | output | 11 | Address of the first occurrence of that power |

## Verification
The pipeline has three register ranks, so a snapshot sampled at one edge shows its power and address after the second edge that follows, and the done pulse with the final peak comes one edge after that. The bench drives one table entry per falling edge and, at the same falling edge, compares the outputs against the entry issued three falling edges earlier and the done flag against the entry issued four earlier, so every comparison lands in the cycle where the result is due. Bubbles, flags on bubbles, ties, a back-to-back rescan with a weaker spectrum and full-scale operands are each streamed this way.

// File: rtl/bf_pkg.sv
package bf_pkg;
    localparam int unsigned BF_NCH = 8;
    localparam int unsigned BF_DW  = 20;
    localparam int unsigned BF_WW  = 16;
    localparam int unsigned BF_AW  = 11;
    localparam int unsigned BF_PW  = 49;

    typedef struct packed {
        logic vld;
        logic first;
        logic last;
    } flags_t;
endpackage

// File: rtl/bf_cmul.sv
module bf_cmul #(
    parameter int unsigned DW    = 20,
    parameter int unsigned WW    = 16,
    parameter int unsigned PRODW = 22
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [DW-1:0]    s_i,
    input  logic signed [DW-1:0]    s_q,
    input  logic signed [WW-1:0]    w_re,
    input  logic signed [WW-1:0]    w_im,
    output logic signed [PRODW-1:0] p_re,
    output logic signed [PRODW-1:0] p_im
);
    localparam int unsigned FW = DW + WW + 1;

    typedef struct packed {
        logic signed [PRODW-1:0] re;
        logic signed [PRODW-1:0] im;
    } cm_t;

    cm_t cm_d, cm_q;
    logic signed [FW-1:0] full_re, full_im;

    always_comb begin
        full_re = s_i * w_re - s_q * w_im;
        full_im = s_i * w_im + s_q * w_re;
        cm_d.re = PRODW'(full_re >>> (WW - 1));
        cm_d.im = PRODW'(full_im >>> (WW - 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cm_q <= '0;
        else        cm_q <= cm_d;
    end

    assign p_re = cm_q.re;
    assign p_im = cm_q.im;
endmodule

// File: rtl/bf_sum.sv
module bf_sum #(
    parameter int unsigned NCH   = 8,
    parameter int unsigned PRODW = 22,
    parameter int unsigned SUMW  = 25
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NCH*PRODW-1:0]    in_re,
    input  logic [NCH*PRODW-1:0]    in_im,
    output logic signed [SUMW-1:0]  out_re,
    output logic signed [SUMW-1:0]  out_im
);
    typedef struct packed {
        logic signed [SUMW-1:0] re;
        logic signed [SUMW-1:0] im;
    } acc_t;

    acc_t acc_d, acc_q;

    always_comb begin
        acc_d = '0;
        for (int n = 0; n < NCH; n++) begin
            acc_d.re = acc_d.re + SUMW'($signed(in_re[n*PRODW +: PRODW]));
            acc_d.im = acc_d.im + SUMW'($signed(in_im[n*PRODW +: PRODW]));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign out_re = acc_q.re;
    assign out_im = acc_q.im;
endmodule

// File: rtl/scan_beamformer.sv
module scan_beamformer
    import bf_pkg::*;
#(
    parameter int unsigned NCH = BF_NCH,
    parameter int unsigned DW  = BF_DW,
    parameter int unsigned WW  = BF_WW,
    parameter int unsigned AW  = BF_AW,
    parameter int unsigned PW  = BF_PW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic              scan_start,
    input  logic              scan_last,
    input  logic [AW-1:0]     wt_addr,
    input  logic [NCH*DW-1:0] smp_i,
    input  logic [NCH*DW-1:0] smp_q,
    input  logic [NCH*WW-1:0] wt_re,
    input  logic [NCH*WW-1:0] wt_im,
    output logic              pw_valid,
    output logic [PW-1:0]     pw_power,
    output logic [AW-1:0]     pw_addr,
    output logic              scan_done,
    output logic [PW-1:0]     peak_power,
    output logic [AW-1:0]     peak_addr
);
    localparam int unsigned PRODW = DW + 2;
    localparam int unsigned SUMW  = PRODW + $clog2(NCH);
    localparam int unsigned SQW   = 2 * SUMW + 1;

    logic [NCH*PRODW-1:0]   prod_re, prod_im;
    logic signed [SUMW-1:0] sum_re, sum_im;

    // one complex weight multiplier per channel
    for (genvar g = 0; g < NCH; g++) begin : g_chan
        bf_cmul #(.DW(DW), .WW(WW), .PRODW(PRODW)) u_cmul (
            .clk  (clk),
            .rst_n(rst_n),
            .s_i  (smp_i[g*DW +: DW]),
            .s_q  (smp_q[g*DW +: DW]),
            .w_re (wt_re[g*WW +: WW]),
            .w_im (wt_im[g*WW +: WW]),
            .p_re (prod_re[g*PRODW +: PRODW]),
            .p_im (prod_im[g*PRODW +: PRODW])
        );
    end

    bf_sum #(.NCH(NCH), .PRODW(PRODW), .SUMW(SUMW)) u_sum (
        .clk   (clk),
        .rst_n (rst_n),
        .in_re (prod_re),
        .in_im (prod_im),
        .out_re(sum_re),
        .out_im(sum_im)
    );

    typedef struct packed {
        flags_t          f_m;     // tag beside the multiplier rank
        logic [AW-1:0]   a_m;
        flags_t          f_s;     // tag beside the sum rank
        logic [AW-1:0]   a_s;
        logic            p_vld;   // power rank
        logic            p_last;
        logic [PW-1:0]   p_pow;
        logic [AW-1:0]   p_addr;
        logic            done;
        logic [PW-1:0]   pk_pow;
        logic [AW-1:0]   pk_addr;
    } st_t;

    st_t st_d, st_q;
    logic signed [SQW-1:0] sq_re, sq_im;
    logic [PW-1:0]         power;

    always_comb begin
        st_d = st_q;

        st_d.f_m.vld   = smp_valid;
        st_d.f_m.first = smp_valid && scan_start;
        st_d.f_m.last  = smp_valid && scan_last;
        st_d.a_m       = wt_addr;

        st_d.f_s = st_q.f_m;
        st_d.a_s = st_q.a_m;

        sq_re = sum_re * sum_re;
        sq_im = sum_im * sum_im;
        power = PW'(sq_re + sq_im);

        st_d.p_vld  = st_q.f_s.vld;
        st_d.p_last = st_q.f_s.vld && st_q.f_s.last;
        if (st_q.f_s.vld) begin
            st_d.p_pow  = power;
            st_d.p_addr = st_q.a_s;
            if (st_q.f_s.first || (power > st_q.pk_pow)) begin
                st_d.pk_pow  = power;
                st_d.pk_addr = st_q.a_s;
            end
        end

        st_d.done = st_q.p_last;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pw_valid   = st_q.p_vld;
    assign pw_power   = st_q.p_pow;
    assign pw_addr    = st_q.p_addr;
    assign scan_done  = st_q.done;
    assign peak_power = st_q.pk_pow;
    assign peak_addr  = st_q.pk_addr;
endmodule

// File: rtl/bf_scan_checker.sv
module bf_scan_checker #(
    parameter int unsigned AW = 11,
    parameter int unsigned PW = 49
) (
    input logic          clk,
    input logic          rst_n,
    input logic          smp_valid,
    input logic [AW-1:0] wt_addr,
    input logic          pw_valid,
    input logic [PW-1:0] pw_power,
    input logic [AW-1:0] pw_addr,
    input logic          scan_done,
    input logic [PW-1:0] peak_power
);
    p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |-> ##3 pw_valid);

    p_bubble_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |-> ##3 !pw_valid);

    p_addr_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pw_valid |-> (pw_addr == $past(wt_addr, 3)));

    p_nonneg_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pw_valid |-> !pw_power[PW-1]);

    p_peak_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pw_valid |-> (peak_power >= pw_power));

    p_peak_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(peak_power) |-> pw_valid);

    p_done_after_r8: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done |-> $past(pw_valid));
endmodule

bind scan_beamformer bf_scan_checker #(.AW(AW), .PW(PW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .wt_addr   (wt_addr),
    .pw_valid  (pw_valid),
    .pw_power  (pw_power),
    .pw_addr   (pw_addr),
    .scan_done (scan_done),
    .peak_power(peak_power)
);

// File: tb/scan_beamformer_test.sv
module scan_beamformer_test;
    localparam int NCH = 8;
    localparam int DW  = 20;
    localparam int WW  = 16;
    localparam int AW  = 11;
    localparam int PW  = 49;
    localparam int MAXE = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              smp_valid = 1'b0;
    logic              scan_start = 1'b0;
    logic              scan_last = 1'b0;
    logic [AW-1:0]     wt_addr = '0;
    logic [NCH*DW-1:0] smp_i = '0;
    logic [NCH*DW-1:0] smp_q = '0;
    logic [NCH*WW-1:0] wt_re = '0;
    logic [NCH*WW-1:0] wt_im = '0;
    logic              pw_valid;
    logic [PW-1:0]     pw_power;
    logic [AW-1:0]     pw_addr;
    logic              scan_done;
    logic [PW-1:0]     peak_power;
    logic [AW-1:0]     peak_addr;

    scan_beamformer uut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .scan_start(scan_start),
        .scan_last(scan_last), .wt_addr(wt_addr), .smp_i(smp_i), .smp_q(smp_q),
        .wt_re(wt_re), .wt_im(wt_im), .pw_valid(pw_valid), .pw_power(pw_power),
        .pw_addr(pw_addr), .scan_done(scan_done), .peak_power(peak_power),
        .peak_addr(peak_addr)
    );

    always #5 clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;

    int e_vld[MAXE], e_first[MAXE], e_last[MAXE], e_addr[MAXE];
    int e_i[MAXE][NCH], e_q[MAXE][NCH], e_wr[MAXE][NCH], e_wi[MAXE][NCH];
    longint model_pk;
    int     model_pa;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // expected power from the arithmetic stated in R1 and R2
    function automatic longint model_power(input int k);
        longint sre = 0, sim = 0;
        for (int n = 0; n < NCH; n++) begin
            longint fr, fi;
            fr = longint'(e_i[k][n]) * e_wr[k][n] - longint'(e_q[k][n]) * e_wi[k][n];
            fi = longint'(e_i[k][n]) * e_wi[k][n] + longint'(e_q[k][n]) * e_wr[k][n];
            sre += (fr >>> 15);
            sim += (fi >>> 15);
        end
        return sre * sre + sim * sim;
    endfunction

    task automatic set_flags(input int k, input int addr, input int vld,
                             input int first, input int last);
        e_addr[k] = addr; e_vld[k] = vld; e_first[k] = first; e_last[k] = last;
    endtask

    task automatic fill(input int k, input int seed, input int scale);
        for (int n = 0; n < NCH; n++) begin
            e_i[k][n]  = (((seed * 7919 + n * 1049 + k * 31) % 2001) - 1000) * scale;
            e_q[k][n]  = (((seed * 337 + n * 2203 + k * 577) % 2001) - 1000) * scale;
            e_wr[k][n] = ((seed * 131 + n * 977 + k * 17) % 65535) - 32767;
            e_wi[k][n] = ((seed * 59 + n * 4001 + k * 613) % 65535) - 32767;
        end
    endtask

    task automatic fill_const(input int k, input int i, input int q,
                              input int wr, input int wi);
        for (int n = 0; n < NCH; n++) begin
            e_i[k][n] = i; e_q[k][n] = q; e_wr[k][n] = wr; e_wi[k][n] = wi;
        end
    endtask

    task automatic drive_entry(input int k);
        smp_valid  = e_vld[k][0];
        scan_start = e_first[k][0];
        scan_last  = e_last[k][0];
        wt_addr    = AW'(e_addr[k]);
        for (int n = 0; n < NCH; n++) begin
            smp_i[n*DW +: DW] = DW'(e_i[k][n]);
            smp_q[n*DW +: DW] = DW'(e_q[k][n]);
            wt_re[n*WW +: WW] = WW'(e_wr[k][n]);
            wt_im[n*WW +: WW] = WW'(e_wi[k][n]);
        end
    endtask

    task automatic drive_idle();
        smp_valid = 1'b0; scan_start = 1'b0; scan_last = 1'b0;
        wt_addr = '0; smp_i = '0; smp_q = '0; wt_re = '0; wt_im = '0;
    endtask

    // Streams K entries one per cycle; entry j is due at the outputs three
    // falling edges after it is driven, its done pulse four falling edges after.
    task automatic run_scan(input int K, input string peak_req);
        for (int t = 0; t < K + 5; t++) begin
            int j, jd;
            bit exp_done;
            @(negedge clk);
            j = t - 3;
            if (j >= 0 && j < K) begin
                if (e_vld[j] != 0) begin
                    longint ep;
                    ep = model_power(j);
                    chk(pw_valid == 1'b1, "R3", "pw_valid for accepted sample", longint'(pw_valid), 1);
                    chk(longint'(pw_power) == ep, "R2", "beam power", longint'(pw_power), ep);
                    chk(int'(pw_addr) == e_addr[j], "R4", "paired address", longint'(pw_addr), e_addr[j]);
                    if (e_first[j] != 0 || ep > model_pk) begin
                        model_pk = ep;
                        model_pa = e_addr[j];
                    end
                end else begin
                    chk(pw_valid == 1'b0, "R5", "pw_valid for bubble", longint'(pw_valid), 0);
                end
            end else if (j >= K) begin
                chk(pw_valid == 1'b0, "R3", "pw_valid after stream", longint'(pw_valid), 0);
            end
            jd = t - 4;
            exp_done = (jd >= 0 && jd < K) ? (e_vld[jd] != 0 && e_last[jd] != 0) : 1'b0;
            chk(scan_done == exp_done, "R8", "scan_done", longint'(scan_done), longint'(exp_done));
            if (exp_done) begin
                chk(longint'(peak_power) == model_pk, peak_req, "peak power", longint'(peak_power), model_pk);
                chk(int'(peak_addr) == model_pa, peak_req, "peak address", longint'(peak_addr), model_pa);
            end
            if (t < K) drive_entry(t);
            else       drive_idle();
        end
    endtask

    task automatic test_reset();
        @(negedge clk);
        chk(pw_valid == 1'b0,  "R9", "reset pw_valid", longint'(pw_valid), 0);
        chk(scan_done == 1'b0, "R9", "reset scan_done", longint'(scan_done), 0);
        chk(pw_power == '0,    "R9", "reset pw_power", longint'(pw_power), 0);
        chk(pw_addr == '0,     "R9", "reset pw_addr", longint'(pw_addr), 0);
        chk(peak_power == '0,  "R9", "reset peak_power", longint'(peak_power), 0);
        chk(peak_addr == '0,   "R9", "reset peak_addr", longint'(peak_addr), 0);
    endtask

    // R1 R2 R3 R4 R8: a full scan with varied data
    task automatic test_basic_scan();
        for (int k = 0; k < 12; k++) begin
            fill(k, 3, 500);
            set_flags(k, 100 + k, 1, k == 0, k == 11);
        end
        run_scan(12, "R8");
    endtask

    // R7: two equal maxima, the earlier address must win
    task automatic test_tie();
        for (int k = 0; k < 6; k++) begin
            fill(k, 11, 40);
            set_flags(k, 500 + k, 1, k == 0, k == 5);
        end
        fill_const(2, 300000, 100000, 32767, 0);
        fill_const(4, 300000, 100000, 32767, 0);
        run_scan(6, "R7");
        chk(int'(peak_addr) == 502, "R7", "tie keeps first address", longint'(peak_addr), 502);
    endtask

    // R6: a weak scan right after a strong one reports its own peak
    task automatic test_rescan();
        longint first_peak;
        for (int k = 0; k < 5; k++) begin
            fill(k, 21, 400);
            set_flags(k, 20 + k, 1, k == 0, k == 4);
        end
        run_scan(5, "R8");
        first_peak = model_pk;
        for (int k = 0; k < 5; k++) begin
            fill(k, 22, 3);
            set_flags(k, 40 + k, 1, k == 0, k == 4);
        end
        run_scan(5, "R6");
        chk(longint'(peak_power) < first_peak, "R6", "new scan peak below old peak",
            longint'(peak_power), first_peak);
    endtask

    // R5 R10: bubbles, including bubbles that carry start and last flags
    task automatic test_bubbles();
        for (int k = 0; k < 7; k++) fill(k, 31, 200);
        fill_const(0, 400000, 0, 32767, 0);     // strongest entry, first of scan
        set_flags(0, 7,  1, 1, 0);
        set_flags(1, 8,  0, 0, 1);              // last flag on a bubble
        set_flags(2, 9,  1, 0, 0);
        set_flags(3, 10, 0, 1, 0);              // start flag on a bubble
        set_flags(4, 11, 1, 0, 0);
        set_flags(5, 12, 0, 0, 0);
        set_flags(6, 13, 1, 0, 1);
        run_scan(7, "R10");
        chk(int'(peak_addr) == 7, "R10", "peak kept across flagged bubble", longint'(peak_addr), 7);
    endtask

    // R1 R2: full-scale operands and rounding of negative products
    task automatic test_extremes();
        fill_const(0, -524288, -524288, -32768, 32767);
        set_flags(0, 2047, 1, 1, 0);
        fill_const(1, 0, 0, 0, 0);
        e_i[1][0] = -3; e_wr[1][0] = 1;
        set_flags(1, 1, 1, 0, 0);
        fill_const(2, 0, 0, 0, 0);
        set_flags(2, 0, 1, 0, 1);
        run_scan(3, "R2");
        chk(model_power(1) == 1, "R1", "bench model of -3>>>15", model_power(1), 1);
        chk(peak_power[PW-1] == 1'b0, "R2", "full-scale power sign bit", longint'(peak_power[PW-1]), 0);
    endtask

    initial begin
        model_pk = 0;
        model_pa = 0;
        drive_idle();
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        test_basic_scan();
        test_tie();
        test_rescan();
        test_bubbles();
        test_extremes();
        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule